// File: doc/BRIEF.md
# Strobe-Qualified Slow-Bus Capture

This block moves a data word from a slow external bus into a fast local clock domain without passing every data bit through its own synchronizer. The slow bus changes its data around the falling edge of a phase strobe. Only that one strobe bit crosses into the fast domain, through a short flip-flop chain, and its falling edge is detected there.

From the detected edge the block opens a guard window. During the window a qualifier is held low, and the qualifier gates the data before it reaches the capture register. The window is sized from the worst-case lead and lag between the fast clock and the strobe edge, rounded up to whole fast cycles. After a programmable hold delay the whole word is loaded at once and a one-cycle valid pulse is raised. If a further strobe edge arrives while a capture is still pending, that capture is abandoned, the delay restarts from the new edge and a one-cycle drop pulse reports the loss.

Top module: `phcap_top`

## Requirements
- R1: The strobe passes through SYNC_STAGES flip-flops (default 2). After the strobe falls, the qualifier first reads 0 in the cycle after the SYNC_STAGES-th rising clock edge.
- R2: QUAL_CYC is the sum of LEAD_PS and TRAIL_PS divided by CLK_PS and rounded up (default 2). The qualifier is 0 in the edge-detection cycle and in the QUAL_CYC cycles that follow it, and is 1 in every other cycle.
- R3: WAIT_CYC is the larger of HOLD_CYC and QUAL_CYC+1 (default 3). The capture register loads the data, ANDed with the qualifier, at rising edge number SYNC_STAGES+1+WAIT_CYC counted from the strobe's fall. It loads the value present at that edge, and valid is 1 for exactly the following cycle.
- R4: Between captures, valid is 0 and the captured word keeps its last value, even while the strobe stays low.
- R5: A rising strobe edge starts no capture and leaves the qualifier at 1.
- R6: A falling edge detected while a capture is pending (0 < remaining count) cancels that capture. The drop output is 1 for the one cycle after detection. The new capture then follows R3, measured from the new edge.
- R7: A synchronous reset clears the synchronizer, the pending count, the word, valid and drop, and leaves the qualifier at 1. A capture pending at reset never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Asynchronous slow-bus phase strobe |
| data_i | input | DATA_W | Slow-bus data word |
| word_o | output | DATA_W | Last captured word |
| valid_o | output | 1 | One-cycle pulse when word_o is refreshed |
| qual_o | output | 1 | Data qualifier, 0 while the bus data may be moving |
| drop_o | output | 1 | One-cycle pulse when a pending capture is cancelled |

## Verification
The hardest case to reach is a second strobe edge that lands inside the pending window. It needs a strobe pulse shorter than the hold delay, and every spacing just inside and just outside the window. The stimulus drops the strobe, raises it one cycle later and drops it again after a swept gap. It checks the drop pulse and both the lost and the restarted capture against arithmetic expectations. A full sweep of all data values also moves the bus data every cycle, so that a capture one edge early or late shows up as a wrong word.

// File: rtl/phcap_pkg.sv
package phcap_pkg;

    // Control outputs of the guard-window timer
    typedef struct packed {
        logic qual;   // data may be sampled
        logic load;   // load the capture register this cycle
        logic drop;   // a pending capture was cancelled (registered)
    } win_ctl_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/phcap_sync.sv
module phcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic d_in;
        if (i == 0) begin : g_first
            assign d_in = async_i;
        end else begin : g_next
            assign d_in = chain_q[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= d_in;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/phcap_edge.sv
module phcap_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic fall_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/phcap_window.sv
module phcap_window
    import phcap_pkg::*;
#(
    parameter int WAIT_CYC = 3,
    parameter int QUAL_CYC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fall_i,
    output win_ctl_t ctl_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC);
    localparam logic [CNT_W-1:0] OPEN_AT  = CNT_W'(WAIT_CYC - QUAL_CYC);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             drop_q;
    logic             pending;

    assign pending = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= fall_i && pending;
            if (fall_i)       cnt_q <= LOAD_VAL;
            else if (pending) cnt_q <= cnt_q - ONE;
        end
    end

    always_comb begin
        ctl_o.qual = !(fall_i || (cnt_q > OPEN_AT));
        ctl_o.load = (cnt_q == ONE) && !fall_i;
        ctl_o.drop = drop_q;
    end
endmodule

// File: rtl/phcap_capture.sv
module phcap_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         qual_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    logic [W-1:0] gated;

    assign gated = data_i & {W{qual_i}};

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) word_o <= gated;
        end
    end
endmodule

// File: rtl/phcap_top.sv
module phcap_top
    import phcap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 2,
    parameter int CLK_PS      = 20000,
    parameter int LEAD_PS     = 20000,
    parameter int TRAIL_PS    = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o,
    output logic              qual_o,
    output logic              drop_o
);
    localparam int QUAL_CYC = int'(ceil_div(LEAD_PS + TRAIL_PS, CLK_PS));
    localparam int WAIT_CYC = int'(max_u(HOLD_CYC, QUAL_CYC + 1));

    logic     strobe_sync;
    logic     strobe_fall;
    win_ctl_t ctl;

    phcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(strobe_i), .sync_o(strobe_sync)
    );

    phcap_edge u_edge (
        .clk(clk), .rst(rst), .lvl_i(strobe_sync), .fall_o(strobe_fall)
    );

    phcap_window #(.WAIT_CYC(WAIT_CYC), .QUAL_CYC(QUAL_CYC)) u_win (
        .clk(clk), .rst(rst), .fall_i(strobe_fall), .ctl_o(ctl)
    );

    phcap_capture #(.W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .load_i(ctl.load), .qual_i(ctl.qual),
        .data_i(data_i), .word_o(word_o), .valid_o(valid_o)
    );

    assign qual_o = ctl.qual;
    assign drop_o = ctl.drop;
endmodule

// File: rtl/phcap_check.sv
module phcap_check #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         sync_last,
    input logic         qual,
    input logic         valid,
    input logic         drop,
    input logic [W-1:0] word
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    assert_fall_closes_R1: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $fell(sync_last) |-> !qual);

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_capture_qualified_R3: assert property (@(posedge clk) disable iff (rst || !armed_q)
        valid |-> $past(qual));

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !valid |-> $stable(word));

    assert_drop_single_R6: assert property (@(posedge clk) disable iff (rst)
        drop |=> !drop);

    assert_drop_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
        drop |-> !valid);

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!valid && !drop && qual && (word == '0)));
endmodule

bind phcap_top phcap_check #(.W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .sync_last(strobe_sync), .qual(qual_o),
    .valid(valid_o), .drop(drop_o), .word(word_o)
);

// File: tb/sim_phcap_top.sv
`timescale 1ns/1ps
module sim_phcap_top;
    localparam int W      = 8;
    localparam int SYNC   = 2;
    localparam int HOLD   = 2;
    localparam int CLK_PS = 20000;
    localparam int LEAD   = 20000;
    localparam int TRAIL  = 5000;
    localparam int QUAL   = (LEAD + TRAIL + CLK_PS - 1) / CLK_PS;
    localparam int WAITC  = (HOLD > QUAL + 1) ? HOLD : QUAL + 1;
    localparam int LAT    = SYNC + 1 + WAITC;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strobe = 1'b1;
    logic [W-1:0] data = '0;
    logic [W-1:0] word;
    logic         valid, qual, drop;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phcap_top #(
        .DATA_W(W), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD),
        .CLK_PS(CLK_PS), .LEAD_PS(LEAD), .TRAIL_PS(TRAIL)
    ) u0 (
        .clk(clk), .rst(rst), .strobe_i(strobe), .data_i(data),
        .word_o(word), .valid_o(valid), .qual_o(qual), .drop_o(drop)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R7: state while reset is applied
        idle(2);
        chk("R7 valid in reset", int'(valid), 0);
        chk("R7 word in reset", int'(word), 0);
        chk("R7 drop in reset", int'(drop), 0);
        chk("R7 qual in reset", int'(qual), 1);
        rst = 1'b0;
        idle(SYNC + 3);

        // R1 R2 R3 R4 R5: capture sweep over every data value
        for (int d = 0; d < 256; d++) begin
            @(negedge clk);
            strobe = 1'b0;
            data = ~W'(d);
            for (int k = 1; k <= LAT + 3; k++) begin
                @(negedge clk);
                if (k == SYNC)
                    chk("R1 qual first low", int'(qual), 0);
                else
                    chk("R2 qual window", int'(qual), (k >= SYNC && k <= SYNC + QUAL) ? 0 : 1);
                chk("R3 valid timing", int'(valid), (k == LAT) ? 1 : 0);
                if (k == LAT) chk("R3 captured word", int'(word), d);
                if (k > LAT)  chk("R4 word held", int'(word), d);
                data = (k == LAT - 1) ? W'(d) : ~W'(d);
            end
            strobe = 1'b1;
            for (int k = 1; k <= SYNC + 3; k++) begin
                @(negedge clk);
                chk("R5 qual on rise", int'(qual), 1);
                chk("R5 valid on rise", int'(valid), 0);
                chk("R5 word on rise", int'(word), d);
            end
        end

        // R6: second falling edge at swept gaps
        for (int g = 2; g <= 8; g++) begin
            @(negedge clk);
            strobe = 1'b0;
            data = W'(8'h40 + g);
            for (int k = 1; k <= g + LAT + 3; k++) begin
                @(negedge clk);
                chk("R6 drop pulse", int'(drop),
                    (k == g + SYNC + 1 && g <= WAITC) ? 1 : 0);
                chk("R6 valid pulse", int'(valid),
                    ((k == g + LAT) || (k == LAT && g > WAITC)) ? 1 : 0);
                if (k == 1) strobe = 1'b1;
                if (k == g) strobe = 1'b0;
            end
            strobe = 1'b1;
            idle(SYNC + 3);
            chk("R6 restarted word", int'(word), 8'h40 + g);
        end

        // R7: reset while a capture is pending
        @(negedge clk);
        strobe = 1'b0;
        data = 8'hC3;
        idle(3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7 word after reset", int'(word), 0);
        chk("R7 valid after reset", int'(valid), 0);
        chk("R7 drop after reset", int'(drop), 0);
        chk("R7 qual after reset", int'(qual), 1);
        for (int k = 1; k <= LAT + 2; k++) begin
            @(negedge clk);
            chk("R7 pending lost", int'(valid), 0);
        end
        chk("R7 word stays clear", int'(word), 0);
        strobe = 1'b1;
        idle(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule